// File: doc/BRIEF.md
# Strobed Host Register Bus Interface

This block sits between a host processor bus and the register set of a serial communications controller. The host sets up a 3-bit register address, a chip enable, a byte-select flag and a read/write flag, and then pulses a data-bus enable strobe. Nothing happens inside the block until that strobe arrives. The strobe and its control bundle are brought into the system clock domain through a short synchronizer. The leading edge starts the transfer and the trailing edge closes it.

Address bits [2:1] pick one of four 16-bit registers, and bit 0 picks its upper or lower half. The address map is as follows:
- index 0 holds receive data (low half) and receive status (high half), and is read-only;
- indices 1 and 2 are general configuration registers;
- index 3 is the transmit data/status register.

A word access moves all 16 bits. A byte access uses only the lane that matches the addressed half. Accesses have side effects: a finished read of the receive halves clears their available flags, and any write to the transmit register clears the buffer-empty flag. The serial engines set these flags again with single-cycle pulses.

Top module: `hbus_regif`

## Requirements
- R1: During and after synchronous reset, the three configuration/transmit registers read 0, the flags rx_da, rx_sa and tx_be are 0, and bus_doe is 0.
- R2: A write with bus_bytesel=0 stores all 16 bits of bus_din into register bus_addr[2:1], and bus_addr[0] is ignored. A word read returns all 16 bits on bus_dout.
- R3: bus_doe is 1 only while a read strobe is in progress that began with bus_ce=1. A strobe with bus_ce=0 changes no register and leaves bus_doe at 0 and bus_dout at 0.
- R4: A byte write (bus_bytesel=1) with bus_addr[0]=1 stores bus_din[15:8] into bits [15:8] only. With bus_addr[0]=0 it stores bus_din[7:0] into bits [7:0] only. The other half keeps its value.
- R5: A byte read of a high half drives bus_dout[15:8] with that half and drives bus_dout[7:0] with 0. A byte read of a low half drives bus_dout[7:0] with that half and drives bus_dout[15:8] with 0.
- R6: Register index 0 reads rx_status in bits [15:8]. Its bits [7:0] hold rx_char zero-extended, so bits above the RXD_W width read 0. Writes to index 0 have no effect.
- R7: At the trailing edge of a read strobe, rx_da clears if the read was a low-byte or word read of index 0. rx_sa clears if the read was a high-byte or word read of index 0. Both flags stay set while the strobe is still high.
- R8: Any completed write to index 3 (high byte, low byte or word) clears tx_be.
- R9: A one-cycle pulse on rx_data_set, rx_stat_set or tx_be_set sets the matching flag. If a set and a clear fall in the same cycle, the set wins.
- R10: Reads of registers other than index 0, and writes to registers other than index 3, leave rx_da, rx_sa and tx_be unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register index [2:1] and half select [0] |
| bus_ce | input | 1 | Chip enable, sampled at strobe leading edge |
| bus_bytesel | input | 1 | 1 = byte transfer, 0 = word transfer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_strobe | input | 1 | Data-bus enable strobe |
| bus_din | input | 16 | Write data from host |
| bus_dout | output | 16 | Read data to host |
| bus_doe | output | 1 | Read data output enable |
| rx_char | input | RXD_W | Received character from receive engine |
| rx_status | input | 8 | Receive status byte |
| rx_data_set | input | 1 | Pulse: new receive character available |
| rx_stat_set | input | 1 | Pulse: new receive status available |
| tx_be_set | input | 1 | Pulse: transmit buffer has emptied |
| rx_da | output | 1 | Receive data available flag |
| rx_sa | output | 1 | Receive status available flag |
| tx_be | output | 1 | Transmit buffer empty flag |
| cfg_a | output | 16 | Configuration register at index 1 |
| cfg_b | output | 16 | Configuration register at index 2 |
| tx_word | output | 16 | Transmit data/status register at index 3 |

## Verification
Every writable register is swept with a set of distinct 16-bit patterns. Word writes are made with both values of the half-select bit, which shows whether that bit is truly ignored. High-byte and low-byte writes are interleaved with the opposite half holding a known, different value, so a wrong lane or a missing byte mask shows up as a mismatch in the untouched half. Byte reads of each half check both the active lane and the zeroed idle lane. The flag tests pair each kind of receive read with the flag it must and must not clear. They also sample the flags mid-strobe and after the trailing edge, which separates clearing at the trailing edge from clearing at the leading edge. Chip-enable-off accesses and accesses to unrelated registers confirm that nothing changes.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int LANE_W = DATA_W / 2;
    localparam int IDX_W  = ADDR_W - 1;
    localparam int NREG   = 1 << IDX_W;
    localparam int RX_IDX = 0;
    localparam int TX_IDX = NREG - 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        idx_t idx;
        logic hi;
        logic byte_mode;
        logic wr;
    } acc_t;

    typedef enum logic [1:0] {
        LANE_BOTH = 2'd0,
        LANE_HI   = 2'd1,
        LANE_LO   = 2'd2
    } lane_e;

    function automatic lane_e lane_of(input acc_t a);
        if (!a.byte_mode) return LANE_BOTH;
        return a.hi ? LANE_HI : LANE_LO;
    endfunction

    function automatic word_t merge_wr(input word_t old, input word_t din, input lane_e ln);
        case (ln)
            LANE_HI: return {din[DATA_W-1:LANE_W], old[LANE_W-1:0]};
            LANE_LO: return {old[DATA_W-1:LANE_W], din[LANE_W-1:0]};
            default: return din;
        endcase
    endfunction

    function automatic word_t steer_rd(input word_t val, input lane_e ln);
        case (ln)
            LANE_HI: return {val[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
            LANE_LO: return {{LANE_W{1'b0}}, val[LANE_W-1:0]};
            default: return val;
        endcase
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbus_strobe_decode.sv
module hbus_strobe_decode
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_s,
    input  logic              ce_s,
    input  logic              wr_s,
    input  logic              bsel_s,
    input  logic [ADDR_W-1:0] addr_s,
    output acc_t              acc_now,
    output acc_t              acc_q,
    output logic              wr_fire,
    output logic              rd_done,
    output logic              doe
);
    logic stb_d;
    logic active_q;
    logic lead, trail;

    assign lead  = stb_s & ~stb_d;
    assign trail = ~stb_s & stb_d;

    assign acc_now = '{idx: addr_s[ADDR_W-1:1], hi: addr_s[0], byte_mode: bsel_s, wr: wr_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_d    <= 1'b0;
            active_q <= 1'b0;
            acc_q    <= '0;
        end else begin
            stb_d <= stb_s;
            if (lead && ce_s) begin
                active_q <= 1'b1;
                acc_q    <= acc_now;
            end else if (trail) begin
                active_q <= 1'b0;
            end
        end
    end

    assign wr_fire = lead & ce_s & wr_s;
    assign rd_done = trail & active_q & ~acc_q.wr;
    assign doe     = active_q & ~acc_q.wr;
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
    import hbus_pkg::*;
#(
    parameter int RXD_W = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_fire,
    input  acc_t                        acc_now,
    input  word_t                       din,
    input  acc_t                        acc_q,
    input  logic                        rd_done,
    input  logic [RXD_W-1:0]            rx_char,
    input  logic [LANE_W-1:0]           rx_status,
    input  logic                        rx_data_set,
    input  logic                        rx_stat_set,
    input  logic                        tx_be_set,
    output word_t                       rd_data,
    output logic [NREG-1:0][DATA_W-1:0] regs_o,
    output logic                        rx_da,
    output logic                        rx_sa,
    output logic                        tx_be
);
    logic [NREG-1:0][DATA_W-1:0] store_q;
    word_t rx_word;
    word_t sel_word;
    logic  rd_rx, clr_da, clr_sa, clr_be;

    assign rx_word = {rx_status, LANE_W'(rx_char)};

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (wr_fire) begin
            for (int r = 0; r < NREG; r++) begin
                if (r != RX_IDX && acc_now.idx == idx_t'(r)) begin
                    store_q[r] <= merge_wr(store_q[r], din, lane_of(acc_now));
                end
            end
        end
    end

    assign sel_word = (acc_q.idx == idx_t'(RX_IDX)) ? rx_word : store_q[acc_q.idx];
    assign rd_data  = steer_rd(sel_word, lane_of(acc_q));
    assign regs_o   = store_q;

    assign rd_rx  = rd_done & (acc_q.idx == idx_t'(RX_IDX));
    assign clr_da = rd_rx & (~acc_q.byte_mode | ~acc_q.hi);
    assign clr_sa = rd_rx & (~acc_q.byte_mode |  acc_q.hi);
    assign clr_be = wr_fire & (acc_now.idx == idx_t'(TX_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_da <= 1'b0;
            rx_sa <= 1'b0;
            tx_be <= 1'b0;
        end else begin
            if (rx_data_set)      rx_da <= 1'b1;
            else if (clr_da)      rx_da <= 1'b0;
            if (rx_stat_set)      rx_sa <= 1'b1;
            else if (clr_sa)      rx_sa <= 1'b0;
            if (tx_be_set)        tx_be <= 1'b1;
            else if (clr_be)      tx_be <= 1'b0;
        end
    end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
    import hbus_pkg::*;
#(
    parameter int RXD_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_ce,
    input  logic              bus_bytesel,
    input  logic              bus_wr,
    input  logic              bus_strobe,
    input  logic [15:0]       bus_din,
    output logic [15:0]       bus_dout,
    output logic              bus_doe,
    input  logic [RXD_W-1:0]  rx_char,
    input  logic [7:0]        rx_status,
    input  logic              rx_data_set,
    input  logic              rx_stat_set,
    input  logic              tx_be_set,
    output logic              rx_da,
    output logic              rx_sa,
    output logic              tx_be,
    output logic [15:0]       cfg_a,
    output logic [15:0]       cfg_b,
    output logic [15:0]       tx_word
);
    localparam int BW = ADDR_W + 4;

    logic [BW-1:0] bundle_raw, bundle_s;
    acc_t  acc_now, acc_q;
    logic  wr_fire, rd_done, doe;
    word_t rd_data;
    logic [NREG-1:0][DATA_W-1:0] regs;

    assign bundle_raw = {bus_strobe, bus_ce, bus_wr, bus_bytesel, bus_addr};

    hbus_sync #(.W(BW), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (bundle_raw),
        .q   (bundle_s)
    );

    hbus_strobe_decode dec_i (
        .clk     (clk),
        .rst     (rst),
        .stb_s   (bundle_s[BW-1]),
        .ce_s    (bundle_s[BW-2]),
        .wr_s    (bundle_s[BW-3]),
        .bsel_s  (bundle_s[BW-4]),
        .addr_s  (bundle_s[ADDR_W-1:0]),
        .acc_now (acc_now),
        .acc_q   (acc_q),
        .wr_fire (wr_fire),
        .rd_done (rd_done),
        .doe     (doe)
    );

    hbus_regfile #(.RXD_W(RXD_W)) rf_i (
        .clk         (clk),
        .rst         (rst),
        .wr_fire     (wr_fire),
        .acc_now     (acc_now),
        .din         (bus_din),
        .acc_q       (acc_q),
        .rd_done     (rd_done),
        .rx_char     (rx_char),
        .rx_status   (rx_status),
        .rx_data_set (rx_data_set),
        .rx_stat_set (rx_stat_set),
        .tx_be_set   (tx_be_set),
        .rd_data     (rd_data),
        .regs_o      (regs),
        .rx_da       (rx_da),
        .rx_sa       (rx_sa),
        .tx_be       (tx_be)
    );

    assign bus_doe  = doe;
    assign bus_dout = doe ? rd_data : '0;
    assign cfg_a    = regs[1];
    assign cfg_b    = regs[2];
    assign tx_word  = regs[TX_IDX];
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk
    import hbus_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic bus_doe,
    input logic rx_da,
    input logic rx_sa,
    input logic tx_be,
    input logic rx_data_set,
    input logic rx_stat_set,
    input logic tx_be_set,
    input logic wr_fire,
    input acc_t acc_now,
    input logic rd_done,
    input acc_t acc_q
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_da && !rx_sa && !tx_be && !bus_doe));

    // R3: the output driver is never on while a write is being launched
    a_r3_no_doe_on_write: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> !wr_fire);

    // R7
    a_r7_da_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_done && acc_q.idx == idx_t'(RX_IDX) && !(acc_q.byte_mode && acc_q.hi) && !rx_data_set)
        |=> !rx_da);

    a_r7_sa_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_done && acc_q.idx == idx_t'(RX_IDX) && !(acc_q.byte_mode && !acc_q.hi) && !rx_stat_set)
        |=> !rx_sa);

    // R8
    a_r8_be_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && acc_now.idx == idx_t'(TX_IDX) && !tx_be_set) |=> !tx_be);

    // R9
    a_r9_da_set_wins: assert property (@(posedge clk) disable iff (rst)
        rx_data_set |=> rx_da);

    a_r9_be_set_wins: assert property (@(posedge clk) disable iff (rst)
        tx_be_set |=> tx_be);
endmodule

bind hbus_regif hbus_regif_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_doe     (bus_doe),
    .rx_da       (rx_da),
    .rx_sa       (rx_sa),
    .tx_be       (tx_be),
    .rx_data_set (rx_data_set),
    .rx_stat_set (rx_stat_set),
    .tx_be_set   (tx_be_set),
    .wr_fire     (wr_fire),
    .acc_now     (acc_now),
    .rd_done     (rd_done),
    .acc_q       (acc_q)
);

// File: tb/hbus_regif_tb_top.sv
module hbus_regif_tb_top;
    localparam int RXD_W = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       bus_addr = '0;
    logic             bus_ce = 1'b0;
    logic             bus_bytesel = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_strobe = 1'b0;
    logic [15:0]      bus_din = '0;
    logic [15:0]      bus_dout;
    logic             bus_doe;
    logic [RXD_W-1:0] rx_char = '0;
    logic [7:0]       rx_status = '0;
    logic             rx_data_set = 1'b0;
    logic             rx_stat_set = 1'b0;
    logic             tx_be_set = 1'b0;
    logic             rx_da, rx_sa, tx_be;
    logic [15:0]      cfg_a, cfg_b, tx_word;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] model [4];
    logic [15:0] rd_q;
    logic        rd_oe;
    logic        mid_da, mid_sa;

    always #2 clk = ~clk;

    hbus_regif #(.RXD_W(RXD_W)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_ce(bus_ce),
        .bus_bytesel(bus_bytesel), .bus_wr(bus_wr), .bus_strobe(bus_strobe),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .rx_char(rx_char), .rx_status(rx_status), .rx_data_set(rx_data_set),
        .rx_stat_set(rx_stat_set), .tx_be_set(tx_be_set), .rx_da(rx_da),
        .rx_sa(rx_sa), .tx_be(tx_be), .cfg_a(cfg_a), .cfg_b(cfg_b), .tx_word(tx_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one strobed access; read data and flags sampled mid-strobe
    task automatic access(input logic [2:0] a, input logic bs, input logic wr,
                          input logic ce, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_bytesel = bs; bus_wr = wr; bus_ce = ce; bus_din = d;
        @(negedge clk);
        bus_strobe = 1'b1;
        repeat (6) @(negedge clk);
        rd_q = bus_dout; rd_oe = bus_doe; mid_da = rx_da; mid_sa = rx_sa;
        bus_strobe = 1'b0;
        repeat (6) @(negedge clk);
        bus_ce = 1'b0;
    endtask

    task automatic pulse_set(input int which);
        @(negedge clk);
        case (which)
            0: rx_data_set = 1'b1;
            1: rx_stat_set = 1'b1;
            default: tx_be_set = 1'b1;
        endcase
        @(negedge clk);
        rx_data_set = 1'b0; rx_stat_set = 1'b0; tx_be_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        chk(req, cfg_a, model[1]);
        chk(req, cfg_b, model[2]);
        chk(req, tx_word, model[3]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk("R1 doe in reset", {15'b0, bus_doe}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 flags", {13'b0, rx_da, rx_sa, tx_be}, 16'h0);
        check_outs("R1 regs");
        for (int r = 1; r < 4; r++) begin
            access(3'(r << 1), 1'b0, 1'b0, 1'b1, 16'h0);
            chk("R1 word read", rd_q, 16'h0);
        end

        // R2: word write/read sweep, half-select toggled
        for (int r = 1; r < 4; r++) begin
            for (int p = 0; p < 8; p++) begin
                logic [15:0] v;
                v = 16'((p * 16'h2493) ^ (r << 13) ^ 16'h5A0F);
                access(3'((r << 1) | (p & 1)), 1'b0, 1'b1, 1'b1, v);
                model[r] = v;
                access(3'((r << 1) | ((p + 1) & 1)), 1'b0, 1'b0, 1'b1, 16'hFFFF);
                chk("R2 word read", rd_q, v);
                chk("R3 doe on read", {15'b0, rd_oe}, 16'h1);
            end
        end
        check_outs("R2 outputs");

        // R4/R5: byte lane writes and reads
        for (int r = 1; r < 4; r++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] hb, lb;
                hb = 8'((p * 37) ^ (r * 11) ^ 8'hC3);
                lb = 8'((p * 53) + r + 8'h1D);
                access(3'((r << 1) | 1), 1'b1, 1'b1, 1'b1, {hb, ~hb});
                model[r][15:8] = hb;
                access(3'(r << 1), 1'b0, 1'b0, 1'b1, 16'h0);
                chk("R4 high byte write", rd_q, model[r]);
                access(3'(r << 1), 1'b1, 1'b1, 1'b1, {~lb, lb});
                model[r][7:0] = lb;
                access(3'(r << 1), 1'b0, 1'b0, 1'b1, 16'h0);
                chk("R4 low byte write", rd_q, model[r]);
                access(3'((r << 1) | 1), 1'b1, 1'b0, 1'b1, 16'h0);
                chk("R5 high byte read", rd_q, {model[r][15:8], 8'h00});
                access(3'(r << 1), 1'b1, 1'b0, 1'b1, 16'h0);
                chk("R5 low byte read", rd_q, {8'h00, model[r][7:0]});
            end
        end
        check_outs("R4 outputs");

        // R3: chip enable off
        access(3'b010, 1'b0, 1'b1, 1'b0, 16'hDEAD);
        check_outs("R3 write with ce off");
        access(3'b010, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R3 read ce off doe", {15'b0, rd_oe}, 16'h0);
        chk("R3 read ce off data", rd_q, 16'h0);
        chk("R3 idle doe", {15'b0, bus_doe}, 16'h0);

        // R6: receive register layout, write ignored
        rx_char = 7'h7F; rx_status = 8'hA5;
        access(3'b000, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R6 rx word", rd_q, 16'hA57F);
        access(3'b001, 1'b1, 1'b0, 1'b1, 16'h0);
        chk("R6 rx status byte", rd_q, 16'hA500);
        access(3'b000, 1'b0, 1'b1, 1'b1, 16'h1234);
        access(3'b000, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R6 rx write ignored", rd_q, 16'hA57F);
        check_outs("R6 outputs");
        rx_char = 7'h2C; rx_status = 8'h3E;
        access(3'b000, 1'b1, 1'b0, 1'b1, 16'h0);
        chk("R6 rx data byte", rd_q, 16'h002C);

        // R7/R9/R10: receive flags
        pulse_set(0); pulse_set(1);
        chk("R9 rx flags set", {14'b0, rx_da, rx_sa}, 16'h3);
        access(3'b010, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R10 other read keeps flags", {14'b0, rx_da, rx_sa}, 16'h3);
        access(3'b000, 1'b1, 1'b0, 1'b1, 16'h0);
        chk("R7 da held mid strobe", {15'b0, mid_da}, 16'h1);
        chk("R7 low read clears da only", {14'b0, rx_da, rx_sa}, 16'h1);
        access(3'b001, 1'b1, 1'b0, 1'b1, 16'h0);
        chk("R7 sa held mid strobe", {15'b0, mid_sa}, 16'h1);
        chk("R7 high read clears sa", {14'b0, rx_da, rx_sa}, 16'h0);
        pulse_set(0); pulse_set(1);
        access(3'b001, 1'b1, 1'b0, 1'b1, 16'h0);
        chk("R7 high read keeps da", {14'b0, rx_da, rx_sa}, 16'h2);
        pulse_set(1);
        access(3'b000, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R7 word read clears both", {14'b0, rx_da, rx_sa}, 16'h0);

        // R8/R9/R10: transmit buffer empty
        for (int m = 0; m < 3; m++) begin
            pulse_set(2);
            chk("R9 tx_be set", {15'b0, tx_be}, 16'h1);
            access(3'b100, 1'b0, 1'b1, 1'b1, 16'h0F0F);
            chk("R10 other write keeps tx_be", {15'b0, tx_be}, 16'h1);
            model[2] = 16'h0F0F;
            case (m)
                0: begin access(3'b111, 1'b1, 1'b1, 1'b1, 16'h9900); model[3][15:8] = 8'h99; end
                1: begin access(3'b110, 1'b1, 1'b1, 1'b1, 16'h0066); model[3][7:0] = 8'h66; end
                default: begin access(3'b110, 1'b0, 1'b1, 1'b1, 16'hBEEF); model[3] = 16'hBEEF; end
            endcase
            chk("R8 tx write clears tx_be", {15'b0, tx_be}, 16'h0);
        end
        check_outs("R8 outputs");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule